// File: doc/BRIEF.md
# Peripheral Event Routing Matrix

This block carries single-cycle event strobes from on-chip peripherals to the action inputs of other peripherals over a dedicated path, so that no processor cycles or interrupts are spent passing a message from one peripheral to another. Typical sources are timer compare or overflow strobes, comparator toggles, pin changes, converter-done strobes and real-time counter overflows. Typical actions are starting a converter, taking an input capture, clocking a timer, triggering a DMA transfer, changing a pin or forcing a PWM fault shutdown.

The matrix has `NUM_CH` independent channels, eight by default. Each channel picks one source strobe through its configuration register and drives its event onto any subset of the `NUM_ACT` action lines. Sources are registered once, and each channel's selected event is registered once, so an unfiltered event reaches its consumers exactly two clock edges after the source rises. Each channel can also enable a digital filter that only passes an event after the source has been high for several consecutive cycles. Software can inject a one-cycle strobe on any set of channels. A lock bit freezes the routing until the next reset.

The configuration port is a simple write strobe with an address and data word. The address map is: addresses `0 .. NUM_CH-1` hold the channel configurations, address `NUM_CH` is the software strobe and address `NUM_CH+1` is the lock.

Top module: `evr_matrix`

## Requirements
- R1: While reset is asserted and directly after it, `chan_o` and `act_o` are all zero, the lock is clear and every channel selects source 0.
- R2: A write to address c (c < NUM_CH) sets channel c: data bits [SEL_W-1:0] give the source index, bit SEL_W enables the filter, and bits [SEL_W+NUM_ACT:SEL_W+1] give the action mask. The new settings apply from the next clock edge.
- R3: With its filter off, a channel selecting source index k (1..NUM_SRC) follows `src_i[k-1]` delayed by exactly two clock edges, one cycle of output for each cycle of input.
- R4: Source index 0, or any index above NUM_SRC, leaves the channel output low.
- R5: `act_o[a]` is the OR of the channel outputs whose action mask has bit a set, in the same cycle as `chan_o`.
- R6: All channels run at the same time and independently. Several channels may select the same source, and several channels may drive the same action line.
- R7: A write to address NUM_CH with data bit c set makes `chan_o[c]` high for exactly one cycle, one clock edge after the write. This happens whatever the channel's source or filter setting is.
- R8: A write to address NUM_CH+1 with data bit 0 set locks the matrix. After that, channel configuration writes are ignored until reset, software strobes still work, and only reset clears the lock.
- R9: With its filter on, a channel passes its source only once that source has been sampled high on FILT_LEN consecutive cycles. The first output comes FILT_LEN-1 cycles later than it would unfiltered. Shorter bursts produce no output at all.
- R10: The highest action line, `act_o[NUM_ACT-1]`, is the PWM fault-shutdown consumer. An unfiltered comparator event routed to it raises it within two clock edges.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Source event strobes; index k selects bit k-1 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration address |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| chan_o | output | NUM_CH | Event output of each channel |
| act_o | output | NUM_ACT | Action lines to consumers; the top bit is the fault shutdown |

## Verification
An unfiltered source event is due on `chan_o` and `act_o` two rising edges after the cycle in which the source was driven. A software strobe is due one edge after its write. A filtered event is due FILT_LEN+1 edges after the source first rises. A configuration write takes effect on the edge that accepts it, so it governs `act_o` immediately and the channel multiplexer from that edge on. The bench drives inputs after the falling edge, advances its own model on each rising edge using the values it drove, and compares both output vectors at the next falling edge. This places every check exactly in the cycle these latencies predict. Directed sequences pin each latency with explicit edge counts, including filter bursts one cycle too short, and seeded random traffic with configuration churn is compared against the model before and after locking.

// File: rtl/evr_pkg.sv
package evr_pkg;

   typedef enum logic [1:0] {
      ACC_CHAN = 2'd0,
      ACC_SWEV = 2'd1,
      ACC_LOCK = 2'd2,
      ACC_NONE = 2'd3
   } acc_kind_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic acc_kind_e decode_acc(input logic [31:0] addr, input int nch);
      if (addr < 32'(nch))
         return ACC_CHAN;
      else if (addr == 32'(nch))
         return ACC_SWEV;
      else if (addr == 32'(nch + 1))
         return ACC_LOCK;
      return ACC_NONE;
   endfunction

endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
   import evr_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int SEL_W   = 4,
   parameter int NUM_ACT = 8,
   parameter int ADDR_W  = 4,
   parameter int CFG_DW  = 13
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [CFG_DW-1:0]                wdata_i,
   output logic [NUM_CH-1:0][SEL_W-1:0]     sel_o,
   output logic [NUM_CH-1:0]                fen_o,
   output logic [NUM_CH-1:0][NUM_ACT-1:0]   mask_o,
   output logic [NUM_CH-1:0]                sw_o
);

   localparam int FEN_BIT  = SEL_W;
   localparam int MASK_LSB = SEL_W + 1;

   acc_kind_e                      acc;
   logic                           lock_q;
   logic                           chan_wr_ok;
   logic [NUM_CH-1:0][SEL_W-1:0]   sel_q;
   logic [NUM_CH-1:0]              fen_q;
   logic [NUM_CH-1:0][NUM_ACT-1:0] mask_q;

   always_comb begin
      acc        = decode_acc(32'(addr_i), NUM_CH);
      chan_wr_ok = we_i && !lock_q && (acc == ACC_CHAN);
   end

   // lock: set by a write, cleared only by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (we_i && (acc == ACC_LOCK) && wdata_i[0])
         lock_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         fen_q  <= '0;
         mask_q <= '0;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (chan_wr_ok && (addr_i == ADDR_W'(c))) begin
               sel_q[c]  <= wdata_i[SEL_W-1:0];
               fen_q[c]  <= wdata_i[FEN_BIT];
               mask_q[c] <= wdata_i[MASK_LSB +: NUM_ACT];
            end
         end
      end
   end

   always_comb sw_o = (we_i && (acc == ACC_SWEV)) ? wdata_i[NUM_CH-1:0] : '0;

   assign sel_o  = sel_q;
   assign fen_o  = fen_q;
   assign mask_o = mask_q;

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);                                                       // R8
   AST_LOCK_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(sel_q) && $stable(fen_q) && $stable(mask_q)));          // R8

endmodule

// File: rtl/evr_src_stage.sv
module evr_src_stage #(
   parameter int NUM_SRC = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_SRC-1:0] src_q_o
);

   // first pipeline stage: every source strobe is captured once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         src_q_o <= '0;
      else
         src_q_o <= src_i;
   end

endmodule

// File: rtl/evr_channel.sv
module evr_channel #(
   parameter int NUM_SRC  = 12,
   parameter int SEL_W    = 4,
   parameter int FILT_LEN = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_q_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               fen_i,
   input  logic               sw_i,
   output logic               ev_o
);

   logic sel_hit;
   logic filt_hit;
   logic routed;
   logic ev_q;

   // index k picks source k-1; 0 and out-of-range values pick nothing
   always_comb begin
      sel_hit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (int'(sel_i) == s + 1)
            sel_hit = src_q_i[s];
      end
   end

   if (FILT_LEN > 1) begin : g_filter
      localparam int CNT_W = $clog2(FILT_LEN);
      localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN - 1);
      logic [CNT_W-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            run_q <= '0;
         else if (!sel_hit)
            run_q <= '0;
         else if (run_q != CNT_TOP)
            run_q <= run_q + 1'b1;
      end

      assign filt_hit = sel_hit && (run_q == CNT_TOP);
   end else begin : g_nofilter
      assign filt_hit = sel_hit;
   end

   assign routed = fen_i ? filt_hit : sel_hit;

   // second pipeline stage: the routed event, plus the software strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ev_q <= 1'b0;
      else
         ev_q <= routed | sw_i;
   end

   assign ev_o = ev_q;

   AST_SW_STROBE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_i |=> ev_q);                                                           // R7
   AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_i == '0) && !sw_i) |=> !ev_q);                                      // R4
   AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fen_i && sel_hit) |=> ev_q);                                            // R3
   AST_FILT_BLOCKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fen_i && !sel_hit && !sw_i) |=> !ev_q);                                  // R9

endmodule

// File: rtl/evr_fanout.sv
module evr_fanout #(
   parameter int NUM_CH  = 8,
   parameter int NUM_ACT = 8
) (
   input  logic [NUM_CH-1:0]              ev_i,
   input  logic [NUM_CH-1:0][NUM_ACT-1:0] mask_i,
   output logic [NUM_ACT-1:0]             act_o
);

   for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
      always_comb begin
         act_o[a] = 1'b0;
         for (int c = 0; c < NUM_CH; c++)
            act_o[a] = act_o[a] | (ev_i[c] & mask_i[c][a]);
      end
   end

endmodule

// File: rtl/evr_matrix.sv
module evr_matrix
   import evr_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int NUM_SRC  = 12,
   parameter int NUM_ACT  = 8,
   parameter int FILT_LEN = 3,
   parameter int SEL_W    = $clog2(NUM_SRC + 1),
   parameter int ADDR_W   = $clog2(NUM_CH + 2),
   parameter int CFG_DW   = max2(SEL_W + 1 + NUM_ACT, NUM_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               cfg_we_i,
   input  logic [ADDR_W-1:0]  cfg_addr_i,
   input  logic [CFG_DW-1:0]  cfg_wdata_i,
   output logic [NUM_CH-1:0]  chan_o,
   output logic [NUM_ACT-1:0] act_o
);

   if (NUM_CH < 1 || NUM_SRC < 1 || NUM_ACT < 1) begin : g_bad_count
      $error("evr_matrix: channel, source and action counts must be positive");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("evr_matrix: FILT_LEN must be at least 1");
   end
   if (SEL_W < $clog2(NUM_SRC + 1)) begin : g_bad_sel
      $error("evr_matrix: SEL_W too narrow for NUM_SRC");
   end
   if (ADDR_W < $clog2(NUM_CH + 2)) begin : g_bad_addr
      $error("evr_matrix: ADDR_W too narrow for the address map");
   end
   if (CFG_DW < SEL_W + 1 + NUM_ACT || CFG_DW < NUM_CH) begin : g_bad_dw
      $error("evr_matrix: CFG_DW too narrow for the configuration fields");
   end

   logic [NUM_SRC-1:0]              src_q;
   logic [NUM_CH-1:0][SEL_W-1:0]    sel;
   logic [NUM_CH-1:0]               fen;
   logic [NUM_CH-1:0][NUM_ACT-1:0]  mask;
   logic [NUM_CH-1:0]               sw;
   logic [NUM_CH-1:0]               ev;

   evr_cfg_regs #(
      .NUM_CH (NUM_CH),
      .SEL_W  (SEL_W),
      .NUM_ACT(NUM_ACT),
      .ADDR_W (ADDR_W),
      .CFG_DW (CFG_DW)
   ) cfg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (cfg_we_i),
      .addr_i (cfg_addr_i),
      .wdata_i(cfg_wdata_i),
      .sel_o  (sel),
      .fen_o  (fen),
      .mask_o (mask),
      .sw_o   (sw)
   );

   evr_src_stage #(
      .NUM_SRC(NUM_SRC)
   ) src_i_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .src_q_o(src_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      evr_channel #(
         .NUM_SRC (NUM_SRC),
         .SEL_W   (SEL_W),
         .FILT_LEN(FILT_LEN)
      ) ch_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_q_i(src_q),
         .sel_i  (sel[c]),
         .fen_i  (fen[c]),
         .sw_i   (sw[c]),
         .ev_o   (ev[c])
      );
   end

   evr_fanout #(
      .NUM_CH (NUM_CH),
      .NUM_ACT(NUM_ACT)
   ) fan_i (
      .ev_i  (ev),
      .mask_i(mask),
      .act_o (act_o)
   );

   assign chan_o = ev;

   AST_ACT_NEEDS_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      (|act_o) |-> (|chan_o));                                                  // R5
   AST_NO_SOURCE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_q == '0) && (sw == '0) && !cfg_we_i) |=> (chan_o == '0));            // R3

endmodule

// File: tb/evr_matrix_tb_top.sv
`timescale 1ns/1ps
module evr_matrix_tb_top;

   localparam int NUM_CH   = 8;
   localparam int NUM_SRC  = 12;
   localparam int NUM_ACT  = 8;
   localparam int FILT_LEN = 3;
   localparam int SEL_W    = $clog2(NUM_SRC + 1);
   localparam int ADDR_W   = $clog2(NUM_CH + 2);
   localparam int CFG_DW   = (SEL_W + 1 + NUM_ACT > NUM_CH) ? SEL_W + 1 + NUM_ACT : NUM_CH;
   localparam int ADDR_SW  = NUM_CH;
   localparam int ADDR_LK  = NUM_CH + 1;
   localparam real TCK     = 8.0;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_SRC-1:0] src = '0;
   logic               we = 1'b0;
   logic [ADDR_W-1:0]  addr = '0;
   logic [CFG_DW-1:0]  wdata = '0;
   logic [NUM_CH-1:0]  chan_o;
   logic [NUM_ACT-1:0] act_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model state
   logic [SEL_W-1:0]   m_sel  [NUM_CH];
   logic               m_fen  [NUM_CH];
   logic [NUM_ACT-1:0] m_mask [NUM_CH];
   int                 m_run  [NUM_CH];
   logic [NUM_CH-1:0]  m_ch;
   logic [NUM_SRC-1:0] m_s1;
   bit                 m_lock;

   always #(TCK / 2.0) clk = ~clk;

   evr_matrix dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src),
      .cfg_we_i   (we),
      .cfg_addr_i (addr),
      .cfg_wdata_i(wdata),
      .chan_o     (chan_o),
      .act_o      (act_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   function automatic logic [NUM_ACT-1:0] exp_act();
      logic [NUM_ACT-1:0] r = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (m_ch[c]) r |= m_mask[c];
      return r;
   endfunction

   function automatic void model_reset();
      for (int c = 0; c < NUM_CH; c++) begin
         m_sel[c] = '0; m_fen[c] = 1'b0; m_mask[c] = '0; m_run[c] = 0;
      end
      m_ch = '0; m_s1 = '0; m_lock = 1'b0;
   endfunction

   function automatic void model_edge();
      logic [NUM_CH-1:0] n_ch;
      for (int c = 0; c < NUM_CH; c++) begin
         bit hit, pass;
         int k = int'(m_sel[c]);
         hit  = (k >= 1 && k <= NUM_SRC) ? m_s1[k-1] : 1'b0;
         pass = hit && (m_run[c] == FILT_LEN - 1);
         n_ch[c] = (m_fen[c] ? pass : hit) |
                   (we && int'(addr) == ADDR_SW && wdata[c]);
         m_run[c] = hit ? ((m_run[c] < FILT_LEN - 1) ? m_run[c] + 1 : m_run[c]) : 0;
      end
      m_ch = n_ch;
      if (we && int'(addr) < NUM_CH && !m_lock) begin
         m_sel[int'(addr)]  = wdata[SEL_W-1:0];
         m_fen[int'(addr)]  = wdata[SEL_W];
         m_mask[int'(addr)] = wdata[SEL_W+1 +: NUM_ACT];
      end
      if (we && int'(addr) == ADDR_LK && wdata[0]) m_lock = 1'b1;
      m_s1 = src;
   endfunction

   task automatic tick(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk((chan_o === m_ch) && (act_o === exp_act()), tag,
          32'({chan_o, act_o}), 32'({m_ch, exp_act()}));
   endtask

   task automatic wr(input int a, input logic [CFG_DW-1:0] d, input string tag);
      we = 1'b1; addr = ADDR_W'(a); wdata = d;
      tick(tag);
      we = 1'b0;
   endtask

   task automatic cfg_chan(input int c, input int sel, input bit fen, input logic [NUM_ACT-1:0] mask);
      wr(c, CFG_DW'({mask, fen, SEL_W'(sel)}), "R2 config write");
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src = '0; we = 1'b0;
      @(posedge clk); @(posedge clk);
      model_reset();
      @(negedge clk);
      chk(chan_o == '0 && act_o == '0, "R1 outputs in reset", 32'({chan_o, act_o}), 32'h0);
      rst_n = 1'b1;
      tick("R1 after reset");
      chk(chan_o == '0 && act_o == '0, "R1 outputs after reset", 32'({chan_o, act_o}), 32'h0);
   endtask

   initial begin : watchdog
      #(TCK * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0017));
      model_reset();
      do_reset();

      // R3 / R5: unfiltered two-edge latency on channel 0
      cfg_chan(0, 1, 1'b0, NUM_ACT'(1));
      src[0] = 1'b1;
      tick("R3 edge1");
      chk(chan_o[0] == 1'b0, "R3 low after one edge", 32'(chan_o[0]), 32'h0);
      src[0] = 1'b0;
      tick("R3 edge2");
      chk(chan_o[0] == 1'b1, "R3 high after two edges", 32'(chan_o[0]), 32'h1);
      chk(act_o[0] == 1'b1, "R5 action follows channel", 32'(act_o), 32'h1);
      tick("R3 edge3");
      chk(chan_o[0] == 1'b0, "R3 one-cycle width", 32'(chan_o[0]), 32'h0);

      // R4: index 0 and out-of-range index stay quiet
      cfg_chan(1, 0, 1'b0, '1);
      cfg_chan(2, NUM_SRC + 1, 1'b0, '1);
      src = '1;
      for (int i = 0; i < 4; i++) begin
         tick("R4 hold");
         chk(chan_o[2:1] == 2'b00, "R4 no-source channels low", 32'(chan_o[2:1]), 32'h0);
      end
      src = '0;
      tick("R4 drain"); tick("R4 drain");
      cfg_chan(1, 0, 1'b0, '0);
      cfg_chan(2, 0, 1'b0, '0);

      // R7: software strobe
      wr(ADDR_SW, CFG_DW'(8'hA5), "R7 strobe write");
      chk(chan_o == NUM_CH'(8'hA5), "R7 strobe one edge after write", 32'(chan_o), 32'hA5);
      tick("R7 strobe end");
      chk(chan_o == '0, "R7 strobe lasts one cycle", 32'(chan_o), 32'h0);

      // R9: filter on channel 3, source 2
      cfg_chan(3, 2, 1'b1, NUM_ACT'(2));
      src[1] = 1'b1;
      for (int k = 1; k <= FILT_LEN + 3; k++) begin
         if (k == FILT_LEN) src[1] = 1'b0;
         tick("R9 short burst");
         chk(chan_o[3] == 1'b0, "R9 short burst rejected", 32'(chan_o[3]), 32'h0);
      end
      src[1] = 1'b1;
      for (int k = 1; k <= 7; k++) begin
         bit e;
         if (k == 6) src[1] = 1'b0;
         tick("R9 long burst");
         e = (k >= FILT_LEN + 1) && (k <= 6);
         chk(chan_o[3] == e, "R9 filtered latency", 32'(chan_o[3]), 32'(e));
      end
      cfg_chan(3, 0, 1'b0, '0);

      // R10: comparator source 3 to fault line
      cfg_chan(4, 3, 1'b0, NUM_ACT'(1) << (NUM_ACT - 1));
      src[2] = 1'b1;
      tick("R10 edge1");
      src[2] = 1'b0;
      tick("R10 edge2");
      chk(act_o[NUM_ACT-1] == 1'b1, "R10 fault within two edges", 32'(act_o), 32'h80);

      // R6: two channels share a source, share an action line
      cfg_chan(5, 4, 1'b0, NUM_ACT'(4));
      cfg_chan(6, 4, 1'b0, NUM_ACT'(12));
      src[3] = 1'b1;
      tick("R6 edge1");
      src[3] = 1'b0;
      tick("R6 edge2");
      chk(chan_o[6:5] == 2'b11 && act_o[3:2] == 2'b11, "R6 parallel channels",
          32'({chan_o[6:5], act_o[3:2]}), 32'hF);

      // seeded random traffic, unlocked
      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom % 100);
         src = src ^ NUM_SRC'($urandom & $urandom);
         if (r < 8) begin
            we = 1'b1; addr = ADDR_W'($urandom % NUM_CH); wdata = CFG_DW'($urandom);
         end else if (r < 11) begin
            we = 1'b1; addr = ADDR_W'(ADDR_SW); wdata = CFG_DW'($urandom);
         end
         tick("R2/R5/R6/R9 random");
         we = 1'b0;
      end

      // R8: lock
      do_reset();
      cfg_chan(0, 1, 1'b0, NUM_ACT'(1));
      wr(ADDR_LK, CFG_DW'(1), "R8 lock write");
      cfg_chan(0, 0, 1'b0, '0);
      src[0] = 1'b1;
      tick("R8 edge1");
      src[0] = 1'b0;
      tick("R8 edge2");
      chk(chan_o[0] == 1'b1 && act_o[0] == 1'b1, "R8 locked config kept",
          32'({chan_o[0], act_o[0]}), 32'h3);
      tick("R8 drain");
      wr(ADDR_SW, CFG_DW'(2), "R8 strobe while locked");
      chk(chan_o == NUM_CH'(2), "R8 strobe works when locked", 32'(chan_o), 32'h2);
      for (int i = 0; i < 500; i++) begin
         int r = int'($urandom % 100);
         src = src ^ NUM_SRC'($urandom & $urandom);
         if (r < 15) begin
            we = 1'b1; addr = ADDR_W'($urandom % NUM_CH); wdata = CFG_DW'($urandom);
         end
         tick("R8 random locked");
         we = 1'b0;
      end
      do_reset();
      cfg_chan(0, 1, 1'b0, NUM_ACT'(1));
      src[0] = 1'b1;
      tick("R8 reset edge1");
      src[0] = 1'b0;
      tick("R8 reset edge2");
      chk(chan_o[0] == 1'b1, "R8 reset clears lock", 32'(chan_o[0]), 32'h1);
      cfg_chan(0, 0, 1'b0, '0);
      src[0] = 1'b1;
      tick("R8 relock edge1");
      src[0] = 1'b0;
      tick("R8 relock edge2");
      chk(chan_o[0] == 1'b0, "R8 writes accepted after reset", 32'(chan_o[0]), 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule